// File: doc/BRIEF.md
# Banked special register file

This block holds the special-function registers of a small 8-bit microcontroller core. It has a single-port byte interface. The core presents a 7-bit file address, and the block extends it to an 8-bit location. For a direct access, the bank-select bit of the status register supplies bit 7. When the file address is zero, the block uses the 8-bit pointer register as the full location instead, which gives indirect addressing. The resolved location is driven out on `eff_addr`, so the neighbouring RAM, timer and port logic can answer for the locations this block does not own.

The block holds these registers:
- the program-counter low byte;
- the status register;
- the pointer register;
- the option register;
- the two port-direction registers;
- the non-volatile memory control register.

Each register takes its power-on value at reset. Read data is combinational from the stored state. Writes take effect on the rising clock edge.

A separate flag port lets the ALU set or clear the low five status bits directly. On any bit where both write in the same cycle, this port wins over a bus write.

Top module: `sfr_bank_file`

## Requirements
- R1: After reset the registers read as follows: status 0x18, pointer 0x00, program-counter low 0x00, option 0xFF, direction A 0x1F, direction B 0xFF, memory control 0x00.
- R2: For a direct access (addr not 0), `eff_addr` = {status bit 5, addr}. The location map is:
  - program-counter low at 0x02 and 0x82;
  - status at 0x03 and 0x83;
  - pointer at 0x04 and 0x84;
  - option at 0x81;
  - direction A at 0x85;
  - direction B at 0x86;
  - memory control at 0x88.
- R3: When addr is 0, `eff_addr` equals the pointer register, and the read or write acts on that location, with bit 7 of the pointer selecting the bank.
- R4: An indirect access whose pointer value is 0x00 or 0x80 reads 0, and a write through it changes no register.
- R5: All other locations read 0, and writes to them change no register. This includes 0x07, 0x87, 0x89, 0x01, 0x05 and 0x06.
- R6: In direction A and memory control, only bits 4:0 are stored. Bits 7:5 of both read as 0.
- R7: A bus write to status updates bits 7:5 and 2:0. Bits 4 (time-out) and 3 (power-down) ignore bus writes.
- R8: `flag_en[i]`/`flag_val[i]` (i=0 carry, 1 digit carry, 2 zero, 3 power-down, 4 time-out) load status bit i on the next edge, and override a same-cycle bus write to that bit.
- R9: `rd_data` and `eff_addr` follow the inputs in the same cycle. A write is visible on reads from the cycle after its clock edge.
- R10: Writing status bit 5 switches the bank used by direct accesses, starting with the access after that write's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | File address from the core |
| wr_en | input | 1 | Write strobe for the addressed location |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the resolved location (0 if not owned) |
| eff_addr | output | 8 | Resolved 8-bit location |
| flag_en | input | 5 | Per-bit enables for direct status flag updates |
| flag_val | input | 5 | Values for the enabled status flags |

## Verification
`rd_data` and `eff_addr` are combinational, so they are due in the same cycle the address is applied. A write, a flag update or a bank switch is due on the first read after the rising edge that captures it. The bench applies each access just after a falling edge and compares both outputs with its model a moment later. It advances its model only after the following rising edge. A register's new value is therefore first expected one full cycle after the stimulus that wrote it.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned ADDR_W = 7;
    parameter int unsigned DIRA_W = 5;
    parameter int unsigned ECON_W = 5;
    parameter int unsigned FLAG_W = 5;

    localparam int unsigned NSEL = 7;
    localparam int SEL_PCL    = 0;
    localparam int SEL_STATUS = 1;
    localparam int SEL_PTR    = 2;
    localparam int SEL_OPTION = 3;
    localparam int SEL_DIRA   = 4;
    localparam int SEL_DIRB   = 5;
    localparam int SEL_ECON   = 6;

    // Full 8-bit locations; mirrored ones are decoded on the low bits only.
    localparam logic [DATA_W-1:0] SEL_LOC [NSEL] = '{
        8'h02, 8'h03, 8'h04, 8'h81, 8'h85, 8'h86, 8'h88
    };
    localparam logic [NSEL-1:0] SEL_MIRROR = 7'b0000111;

    localparam int ST_BANK = 5;
    localparam logic [DATA_W-1:0] STATUS_BUS_MASK = 8'hE7;

    typedef struct packed {
        logic [DATA_W-1:0] pcl;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] option;
        logic [DIRA_W-1:0] dira;
        logic [DATA_W-1:0] dirb;
        logic [ECON_W-1:0] econ;
    } sfr_state_t;

    localparam sfr_state_t SFR_RESET = '{
        pcl:    '0,
        status: 8'h18,
        ptr:    '0,
        option: '1,
        dira:   '1,
        dirb:   '1,
        econ:   '0
    };
endpackage

// File: rtl/sfr_addr_resolve.sv
module sfr_addr_resolve
    import sfr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ptr,
    input  logic              bank,
    output logic [DATA_W-1:0] eff_addr,
    output logic [NSEL-1:0]   sel
);
    localparam int unsigned LOW_W = DATA_W - 1;

    logic indirect;

    always_comb begin
        indirect = (addr == '0);
        eff_addr = indirect ? ptr : {bank, addr};
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        if (SEL_MIRROR[g]) begin : g_mirror
            assign sel[g] = (eff_addr[LOW_W-1:0] == SEL_LOC[g][LOW_W-1:0]);
        end else begin : g_banked
            assign sel[g] = (eff_addr == SEL_LOC[g]);
        end
    end

    always_comb begin
        assert ($onehot0(sel)) else $error("AST_SEL_ONEHOT"); // R2
    end
endmodule

// File: rtl/sfr_read_mux.sv
module sfr_read_mux
    import sfr_pkg::*;
(
    input  logic [NSEL-1:0]   sel,
    input  sfr_state_t        st,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (sel[SEL_PCL])    rd_data = rd_data | st.pcl;
        if (sel[SEL_STATUS]) rd_data = rd_data | st.status;
        if (sel[SEL_PTR])    rd_data = rd_data | st.ptr;
        if (sel[SEL_OPTION]) rd_data = rd_data | st.option;
        if (sel[SEL_DIRA])   rd_data = rd_data | DATA_W'(st.dira);
        if (sel[SEL_DIRB])   rd_data = rd_data | st.dirb;
        if (sel[SEL_ECON])   rd_data = rd_data | DATA_W'(st.econ);
    end

    always_comb begin
        if (sel[SEL_DIRA] || sel[SEL_ECON])
            assert (rd_data[DATA_W-1:DIRA_W] == '0) else $error("AST_UNIMP_ZERO"); // R6
        if (sel == '0)
            assert (rd_data == '0) else $error("AST_UNOWNED_ZERO"); // R5
    end
endmodule

// File: rtl/sfr_bank_file.sv
module sfr_bank_file
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [7:0]        eff_addr,
    input  logic [4:0]        flag_en,
    input  logic [4:0]        flag_val
);
    sfr_state_t    cur_q;
    sfr_state_t    nxt_d;
    logic [NSEL-1:0] sel;

    sfr_addr_resolve u_resolve (
        .addr     (addr),
        .ptr      (cur_q.ptr),
        .bank     (cur_q.status[ST_BANK]),
        .eff_addr (eff_addr),
        .sel      (sel)
    );

    sfr_read_mux u_rmux (
        .sel     (sel),
        .st      (cur_q),
        .rd_data (rd_data)
    );

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            if (sel[SEL_PCL])    nxt_d.pcl    = wr_data;
            if (sel[SEL_STATUS]) nxt_d.status = (cur_q.status & ~STATUS_BUS_MASK)
                                              | (wr_data & STATUS_BUS_MASK);
            if (sel[SEL_PTR])    nxt_d.ptr    = wr_data;
            if (sel[SEL_OPTION]) nxt_d.option = wr_data;
            if (sel[SEL_DIRA])   nxt_d.dira   = wr_data[DIRA_W-1:0];
            if (sel[SEL_DIRB])   nxt_d.dirb   = wr_data;
            if (sel[SEL_ECON])   nxt_d.econ   = wr_data[ECON_W-1:0];
        end
        for (int i = 0; i < FLAG_W; i++) begin
            if (flag_en[i]) nxt_d.status[i] = flag_val[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SFR_RESET;
        else        cur_q <= nxt_d;
    end

    AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en != '0) |=> (((cur_q.status[FLAG_W-1:0] ^ $past(flag_val)) & $past(flag_en)) == '0)); // R8

    AST_TOPD_BUS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en[4:3] == '0) |=> (cur_q.status[4:3] == $past(cur_q.status[4:3]))); // R7

    AST_UNOWNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && flag_en == '0) |=> (cur_q == $past(cur_q))); // R5

    AST_NULL_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0 && cur_q.ptr[ADDR_W-1:0] == '0) |-> (rd_data == '0)); // R4

    AST_DIRECT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != '0) |-> (eff_addr[DATA_W-1] == cur_q.status[ST_BANK])); // R10
endmodule

// File: tb/sim_sfr_bank_file.sv
module sim_sfr_bank_file;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] eff_addr;
    logic [4:0] flag_en = '0;
    logic [4:0] flag_val = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_pcl, m_st, m_ptr, m_opt, m_da, m_db, m_ec;

    always #5 clk = ~clk;

    sfr_bank_file u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eff_addr(eff_addr), .flag_en(flag_en), .flag_val(flag_val)
    );

    function automatic int m_eff(int a);
        if (a == 0) return m_ptr;
        return ((m_st >> 5) & 1) * 128 + a;
    endfunction

    function automatic int m_read(int ea);
        case (ea)
            8'h02, 8'h82: return m_pcl;
            8'h03, 8'h83: return m_st;
            8'h04, 8'h84: return m_ptr;
            8'h81: return m_opt;
            8'h85: return m_da;
            8'h86: return m_db;
            8'h88: return m_ec;
            default: return 0;
        endcase
    endfunction

    task automatic m_write(int ea, int d);
        case (ea)
            8'h02, 8'h82: m_pcl = d;
            8'h03, 8'h83: m_st = (m_st & 8'h18) | (d & 8'hE7);
            8'h04, 8'h84: m_ptr = d;
            8'h81: m_opt = d;
            8'h85: m_da = d & 8'h1F;
            8'h86: m_db = d;
            8'h88: m_ec = d & 8'h1F;
            default: ;
        endcase
    endtask

    task automatic m_reset();
        m_pcl = 0; m_st = 8'h18; m_ptr = 0; m_opt = 8'hFF;
        m_da = 8'h1F; m_db = 8'hFF; m_ec = 0;
    endtask

    task automatic check(int act, int exp, string tag, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic step(int a, int we, int d, int fen, int fval, string tag);
        int ea;
        @(negedge clk);
        addr = 7'(a); wr_en = we[0]; wr_data = 8'(d);
        flag_en = 5'(fen); flag_val = 5'(fval);
        #1;
        ea = m_eff(a);
        check(int'(eff_addr), ea, tag, "eff_addr");
        check(int'(rd_data), m_read(ea), tag, "rd_data");
        @(posedge clk);
        if (we != 0) m_write(ea, d);
        for (int i = 0; i < 5; i++)
            if (((fen >> i) & 1) != 0) m_st = (m_st & ~(1 << i)) | (((fval >> i) & 1) << i);
    endtask

    task automatic rd(int a, string tag);
        step(a, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(int a, int d, string tag);
        step(a, 1, d, 0, 0, tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values, bank 0 then bank 1
        rd(2, "R1"); rd(3, "R1"); rd(4, "R1");
        wr(3, 8'h38, "R10");                    // select bank 1
        rd(8'h01, "R1"); rd(8'h05, "R1"); rd(8'h06, "R1"); rd(8'h08, "R1");
        rd(8'h03, "R2");                        // status mirror at 0x83

        // R2 / R9 write and read back in bank 1
        wr(8'h01, 8'hA5, "R2"); rd(8'h01, "R9");
        wr(8'h06, 8'h3C, "R2"); rd(8'h06, "R9");
        wr(8'h04, 8'h5A, "R2"); rd(8'h04, "R2"); // pointer mirror

        // R6 unimplemented bits
        wr(8'h05, 8'hFF, "R6"); rd(8'h05, "R6");
        wr(8'h08, 8'hEA, "R6"); rd(8'h08, "R6");

        // R5 unused locations in bank 1
        wr(8'h07, 8'hFF, "R5"); rd(8'h07, "R5");
        wr(8'h09, 8'h77, "R5"); rd(8'h09, "R5");
        rd(8'h01, "R5");

        // R10 back to bank 0
        wr(8'h03, 8'h00, "R10"); rd(8'h01, "R10"); rd(8'h05, "R10");
        wr(8'h06, 8'h99, "R5"); rd(8'h06, "R5");
        rd(8'h07, "R5");
        wr(8'h02, 8'h81, "R2"); rd(8'h02, "R9");

        // R3 indirect access across banks
        wr(8'h04, 8'h86, "R3"); rd(0, "R3");
        wr(0, 8'h42, "R3"); rd(0, "R3");
        wr(8'h04, 8'h02, "R3"); rd(0, "R3");
        wr(0, 8'h11, "R3"); rd(8'h02, "R3");
        wr(8'h04, 8'h83, "R3"); wr(0, 8'h20, "R3"); rd(8'h01, "R3"); // bank via pointer write
        wr(8'h03, 8'h00, "R3");

        // R4 null pointer
        wr(8'h04, 8'h00, "R4"); wr(0, 8'hFF, "R4"); rd(0, "R4"); rd(8'h04, "R4");
        wr(8'h04, 8'h80, "R4"); wr(0, 8'hFF, "R4"); rd(0, "R4"); rd(8'h03, "R4");

        // R7 time-out / power-down locked against bus writes
        wr(8'h03, 8'hFF, "R7"); rd(8'h03, "R7");
        wr(8'h03, 8'h00, "R7"); rd(8'h03, "R7");

        // R8 flag port
        step(8'h02, 0, 0, 5'b00111, 5'b00101, "R8"); rd(8'h03, "R8");
        step(8'h03, 1, 8'h07, 5'b00101, 5'b00000, "R8"); rd(8'h03, "R8");
        step(8'h03, 0, 0, 5'b11000, 5'b01000, "R8"); rd(8'h03, "R8");
        step(8'h03, 1, 8'hE0, 5'b10000, 5'b10000, "R8"); rd(8'h03, "R8");
        rd(8'h04, "R8");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule